// File: doc/BRIEF.md
# Byte-serial CRC-32 engine

The engine folds a stream of bytes into a 32-bit cyclic redundancy check, one byte per clock. Its generator polynomial is x^32 + x^29 + x^18 + x^14 + x^3 + 1, which is 0x20044009 with the x^32 term left implicit. Bits are consumed most significant first. Neither the input bytes nor the result are bit-reversed, and no final inversion is applied, so the output is the raw contents of the CRC register.

A message begins with a start strobe, which loads a seed chosen by the caller. The seed is normally 0xFFFFFFFF. A non-default seed lets a CRC run on across several segments: the result of one segment becomes the seed of the next. The first byte may arrive in the same cycle as the start strobe. A flag on the final byte asks for a one-cycle done pulse, which appears together with the final CRC value. The per-byte update can be built in one of two ways: a 256-entry table computed at elaboration, or an unrolled eight-step shift/XOR network.

Top module: `bytecrc_engine`

## Requirements
- R1: While reset is asserted, and directly after it, `crc_o` reads 0xFFFFFFFF (the `SEED_RST` default) and `done_o` reads 0. Asserting reset in the middle of a message forces these values at once, without waiting for a clock.
- R2: A cycle with `start_i` high and `byte_valid_i` low loads `seed_i` into the CRC register. The seed appears on `crc_o` after the next rising edge.
- R3: A cycle with `start_i` and `byte_valid_i` both high folds `byte_i` into `seed_i`. Whatever the register held before plays no part.
- R4: For each accepted byte, the index is CRC bits 31:24 XOR the byte, and the new CRC is (old CRC << 8) XOR T[index]. Entry T[i] is i placed in bits 31:24 and then shifted left eight times; on each shift, 0x20044009 is XORed in when the bit leaving bit 31 was 1.
- R5: The bytes 0x01, 0x02, 0x03, 0x04 (in that order) from seed 0xFFFFFFFF give 0xF33CB7D3. This holds even when idle cycles are placed between the bytes.
- R6: When neither `start_i` nor `byte_valid_i` is high, `crc_o` keeps its value, whatever `byte_i` carries.
- R7: `done_o` is 1 for exactly the cycle after a cycle with `last_i` high, and 0 after every other cycle.
- R8: A message of zero length (`start_i` and `last_i` high, `byte_valid_i` low) shows the seed unchanged on `crc_o`, with `done_o` high.
- R9: The CRC of one segment, used as the seed for the following segment, gives the same result as a single pass over the joined bytes.
- R10: Each accepted byte changes `crc_o` on the first rising edge after it is presented, so every prefix of a message can be read one cycle behind its last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a message: use `seed_i` as the starting value this cycle |
| seed_i | input | 32 | Starting CRC value, sampled when `start_i` is high |
| byte_valid_i | input | 1 | `byte_i` holds a byte to fold in this cycle |
| byte_i | input | 8 | Message byte |
| last_i | input | 1 | This cycle closes the message; `done_o` pulses one cycle later |
| crc_o | output | 32 | Registered running CRC, raw and without reflection |
| done_o | output | 1 | One-cycle pulse marking the final CRC of a message |

## Verification
The byte update is driven with several kinds of message: an all-zero byte into a seed whose top byte is all ones, runs of 0xFF into a mixed seed, a lone high bit followed by zeros, and arbitrary bytes from seeds of zero and other non-default values. Together these separate a correct polynomial and table index from a reflected, inverted or wrongly indexed variant. The fixed four-byte check value pins down the exact bit order. Every prefix is compared against a bit-at-a-time model, which catches a wrong latency or a seed that gets used twice. Further directed messages tell apart a seed load with and without a byte, a gap inside a message, a zero-length message and a segmented continuation, and so show whether the start strobe chooses the seed over the stale register value.

// File: rtl/bytecrc_pkg.sv
package bytecrc_pkg;

  localparam int unsigned CRC_W  = 32;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned TBL_N  = 1 << DATA_W;
  localparam int unsigned PAD_W  = CRC_W - DATA_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] dat_t;

  // One table row: index in the top byte, then DATA_W polynomial-division shifts.
  function automatic crc_t table_entry(crc_t poly, dat_t idx);
    crc_t r;
    r = {idx, {PAD_W{1'b0}}};
    for (int k = 0; k < DATA_W; k++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

  // Same fold written as a shift register that takes the whole byte into its top.
  function automatic crc_t fold_byte(crc_t poly, crc_t cur, dat_t d);
    crc_t r;
    r = cur ^ {d, {PAD_W{1'b0}}};
    for (int k = 0; k < DATA_W; k++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/bytecrc_rstsync.sv
module bytecrc_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bytecrc_step.sv
module bytecrc_step
  import bytecrc_pkg::*;
#(
  parameter crc_t POLY      = 32'h2004_4009,
  parameter bit   USE_TABLE = 1'b1
) (
  input  crc_t crc_i,
  input  dat_t data_i,
  output crc_t crc_o
);

  if (USE_TABLE) begin : g_table
    crc_t lut [TBL_N];
    dat_t idx;

    for (genvar g = 0; g < TBL_N; g++) begin : g_row
      assign lut[g] = table_entry(POLY, dat_t'(g));
    end

    assign idx   = crc_i[CRC_W-1 -: DATA_W] ^ data_i;
    assign crc_o = (crc_i << DATA_W) ^ lut[idx];

    // Table lookup must match the plain shift-register fold of the same byte.
    always_comb begin
      if (!$isunknown({crc_i, data_i})) begin
        assert_table_vs_fold_R4: assert (crc_o == fold_byte(POLY, crc_i, data_i))
          else $error("table step differs from serial fold");
      end
    end
  end else begin : g_xor
    crc_t acc [DATA_W+1];

    assign acc[0] = crc_i ^ {data_i, {PAD_W{1'b0}}};
    for (genvar s = 0; s < DATA_W; s++) begin : g_shift
      assign acc[s+1] = acc[s][CRC_W-1] ? ((acc[s] << 1) ^ POLY) : (acc[s] << 1);
    end
    assign crc_o = acc[DATA_W];
  end

endmodule

// File: rtl/bytecrc_engine.sv
module bytecrc_engine
  import bytecrc_pkg::*;
#(
  parameter logic [31:0] POLY      = 32'h2004_4009,
  parameter logic [31:0] SEED_RST  = 32'hFFFF_FFFF,
  parameter bit          USE_TABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] seed_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  output logic [31:0] crc_o,
  output logic        done_o
);

  logic rst_sync_n;
  crc_t crc_q, crc_d, base, stepped;
  logic crc_en;
  logic done_q, done_d;

  bytecrc_rstsync #(.STAGES(2)) u_rstsync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // A start strobe replaces the running value with the seed before any fold.
  assign base = start_i ? seed_i : crc_q;

  bytecrc_step #(.POLY(POLY), .USE_TABLE(USE_TABLE)) u_step (
    .crc_i  (base),
    .data_i (byte_i),
    .crc_o  (stepped)
  );

  always_comb begin
    crc_en = start_i | byte_valid_i;
    crc_d  = byte_valid_i ? stepped : base;
    done_d = last_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      crc_q <= SEED_RST;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !byte_valid_i) |=> $stable(crc_o))
    else $error("crc changed without start or byte");

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !byte_valid_i) |=> (crc_o == $past(seed_i)))
    else $error("seed not loaded");

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && last_i && !byte_valid_i) |=> (done_o && (crc_o == $past(seed_i))))
    else $error("empty message did not return seed");

endmodule

// File: tb/test_bytecrc_engine.sv
module test_bytecrc_engine;

  localparam time         HALF_PERIOD = 10ns;
  localparam logic [31:0] POLY        = 32'h2004_4009;
  localparam int          WATCHDOG    = 20000;

  typedef struct packed {
    logic [31:0] seed;
    logic [2:0]  len;
    logic [31:0] bytes;    // first byte in 31:24
    logic        use_gold;
    logic [31:0] gold;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFF_FFFF, 3'd4, 32'h0102_0304, 1'b1, 32'hF33C_B7D3},
    '{32'hFFFF_FFFF, 3'd1, 32'h0000_0000, 1'b0, 32'h0},
    '{32'h0000_0000, 3'd2, 32'hAA55_0000, 1'b0, 32'h0},
    '{32'h1234_5678, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0},
    '{32'hFFFF_FFFF, 3'd3, 32'h8000_0100, 1'b0, 32'h0},
    '{32'hDEAD_BEEF, 3'd4, 32'h1020_3040, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        last_i = 1'b0;
  logic [31:0] crc_o;
  logic        done_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(HALF_PERIOD) clk = ~clk;

  bytecrc_engine i_bytecrc_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .seed_i       (seed_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .last_i       (last_i),
    .crc_o        (crc_o),
    .done_o       (done_o)
  );

  // Bit-at-a-time model, MSB first.
  function automatic logic [31:0] model(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int b = 7; b >= 0; b--) begin
      fb = c[31] ^ d[b];
      c  = c << 1;
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; outputs are read at the next falling edge.
  task automatic apply(logic st, logic v, logic [7:0] b, logic l, logic [31:0] s);
    start_i = st; byte_valid_i = v; byte_i = b; last_i = l; seed_i = s;
    @(negedge clk);
    start_i = 1'b0; byte_valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog on all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] mid;
    logic [31:0] held;

    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1 crc in reset", crc_o, 32'hFFFF_FFFF);
    check("R1 done in reset", {31'b0, done_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 crc after release", crc_o, 32'hFFFF_FFFF);

    if (model(model(model(model(32'hFFFF_FFFF, 8'h01), 8'h02), 8'h03), 8'h04) != 32'hF33C_B7D3)
      $display("note: bench model disagrees with check value");

    // R4 R10 R7 R3 R5: vector walk, every prefix checked
    for (int v = 0; v < NVEC; v++) begin
      exp = VECS[v].seed;
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        logic [7:0] b;
        b   = VECS[v].bytes[31-8*i -: 8];
        exp = model(exp, b);
        apply(i == 0, 1'b1, b, i == int'(VECS[v].len) - 1, VECS[v].seed);
        check($sformatf("R4 R10 vec%0d byte%0d", v, i), crc_o, exp);
        check($sformatf("R7 vec%0d byte%0d done", v, i), {31'b0, done_o},
              {31'b0, i == int'(VECS[v].len) - 1});
      end
      if (VECS[v].use_gold) check("R5 check value", crc_o, VECS[v].gold);
    end

    // R6: idle cycles with noise on byte_i
    held = crc_o;
    for (int k = 0; k < 3; k++) begin
      apply(1'b0, 1'b0, 8'hA5 + 8'(k), 1'b0, 32'h1111_1111);
      check("R6 hold when idle", crc_o, held);
      check("R7 done low when idle", {31'b0, done_o}, 32'h0);
    end

    // R2: seed load without a byte
    apply(1'b1, 1'b0, 8'h77, 1'b0, 32'h0BAD_F00D);
    check("R2 seed load", crc_o, 32'h0BAD_F00D);
    check("R2 done low", {31'b0, done_o}, 32'h0);

    // R3: start with byte ignores the stale register
    apply(1'b1, 1'b1, 8'h5A, 1'b1, 32'h0000_0001);
    check("R3 start with byte", crc_o, model(32'h0000_0001, 8'h5A));
    check("R7 single byte done", {31'b0, done_o}, 32'h1);

    // R5 R6: gaps inside the message
    apply(1'b1, 1'b1, 8'h01, 1'b0, 32'hFFFF_FFFF);
    apply(1'b0, 1'b0, 8'hEE, 1'b0, 32'h0);
    apply(1'b0, 1'b1, 8'h02, 1'b0, 32'h0);
    apply(1'b0, 1'b0, 8'h33, 1'b0, 32'h0);
    apply(1'b0, 1'b0, 8'h44, 1'b0, 32'h0);
    apply(1'b0, 1'b1, 8'h03, 1'b0, 32'h0);
    apply(1'b0, 1'b1, 8'h04, 1'b1, 32'h0);
    check("R5 check value with gaps", crc_o, 32'hF33C_B7D3);

    // R8: zero-length message
    apply(1'b1, 1'b0, 8'h99, 1'b1, 32'hCAFE_F00D);
    check("R8 empty returns seed", crc_o, 32'hCAFE_F00D);
    check("R8 empty done", {31'b0, done_o}, 32'h1);
    apply(1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
    check("R7 done one cycle only", {31'b0, done_o}, 32'h0);

    // R9: two segments chained through the seed
    apply(1'b1, 1'b1, 8'h01, 1'b0, 32'hFFFF_FFFF);
    apply(1'b0, 1'b1, 8'h02, 1'b1, 32'h0);
    mid = crc_o;
    apply(1'b1, 1'b1, 8'h03, 1'b0, mid);
    apply(1'b0, 1'b1, 8'h04, 1'b1, 32'h0);
    check("R9 segmented equals whole", crc_o, 32'hF33C_B7D3);

    // R1: asynchronous reset mid-message
    apply(1'b1, 1'b1, 8'h12, 1'b1, 32'h0);
    #(HALF_PERIOD / 2);
    rst_n = 1'b0;
    #1;
    check("R1 async reset crc", crc_o, 32'hFFFF_FFFF);
    check("R1 async reset done", {31'b0, done_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule